// File: doc/BRIEF.md
# Staged Three-Stage Clock Divider Bank

This block holds the divide settings for three clock stages (input, feedback and output) and produces one divided clock per stage from a single reference clock. Software programs each stage through a 32-bit word-addressed register port. A stage register gives a high-phase cycle count, a low-phase cycle count, an odd-ratio flag and a pass-through flag. A hold flag decides whether a write only stages the value or also applies it.

Every write lands in a shadow copy, and the write data is always merged in first. A write with the hold flag clear copies all three shadows into the active settings in the same cycle, so the three stages never run with a mix of old and new values. Each stage picks up new active values only when its current output period ends. A status word reports a lock flag and an error flag. Lock drops on every apply and returns after a fixed number of reference cycles, which stands in for the relock time of an analogue loop. The default of 25000 cycles gives 100 us at 250 MHz.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset all three stage registers read 0x0000_2000 (pass-through set, counts zero), the status word reads 0x1, `lock_o` is 1 and `err_o` is 0.
- R2: Address bits [3:2] select the word, and bits [1:0] are ignored. Selects 0, 1 and 2 are the input, feedback and output stage registers. Select 3 is the read-only status word, with lock in bit 0 and error in bit 1, and writes to it change nothing. A stage register reads back bits 14:0 as written and bits 31:15 as zero.
- R3: A stage write with bit 14 (hold) set changes only that shadow: the divided clocks and the lock flag are unaffected.
- R4: A stage write with bit 14 clear copies all three shadows, including this write, into the active settings at that clock edge.
- R5: A stage that is not in pass-through drives its clock high for the count in bits 11:6 and then low for the count in bits 5:0, so the ratio is their sum. An odd ratio N is encoded as high N>>1 and low (N>>1)+1.
- R6: A stage with bit 13 (pass-through) set outputs the reference clock itself, which is a ratio of 1.
- R7: Bit 12 (odd-ratio flag) is stored and read back but does not change output timing.
- R8: A stage loads new active values only at the end of a full low phase, so an apply never shortens the phase in progress.
- R9: On an apply edge, lock falls. It rises again after RELOCK_CYCLES cycles with no further apply. An apply made during relock restarts the count.
- R10: On an apply, the error flag is set when a stage that is not in pass-through has a zero high or low count. It is cleared by the next apply without such a stage. A zero count runs as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| div_clk_o | output | 3 | Divided clocks: bit 0 input, bit 1 feedback, bit 2 output stage |
| lock_o | output | 1 | Lock flag |
| err_o | output | 1 | Error flag |

## Verification
The assertions check the following on every cycle:
- a hold write leaves the active settings untouched;
- after an apply, every shadow equals its active copy;
- lock falls on each apply and rises when the relock count expires;
- the error flag moves only on an apply;
- a stage counter never runs past its high count;
- a stage never reloads during or just after its high phase.

Only the bench scenarios can show the following:
- the measured high and low run lengths for even, odd and zero-count settings;
- pass-through following the reference clock;
- the full-length phase that is in progress when an apply arrives mid-period;
- the absolute relock length, including a restart.

// File: rtl/clkdiv_pkg.sv
// Shared types and constants for the clock divider bank.
// Assumes the stage register layout below; other modules decode it directly.
package clkdiv_pkg;
    localparam int NUM_STAGES = 3;
    localparam int CNT_W      = 6;
    localparam int CFG_W      = 2 * CNT_W + 3;
    localparam int HOLD_BIT   = CFG_W - 1;

    // Stage register fields, MSB first: hold(14) pass(13) odd(12) hi(11:6) lo(5:0)
    typedef struct packed {
        logic             hold;
        logic             pass;
        logic             odd_flag;
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] lo_cnt;
    } div_cfg_t;

    localparam div_cfg_t RESET_CFG = '{hold: 1'b0, pass: 1'b1, odd_flag: 1'b0,
                                       hi_cnt: '0, lo_cnt: '0};
endpackage

// File: rtl/clkdiv_regs.sv
// Register decode with shadow and active copies of the stage settings.
// Assumes word-aligned decode on addr[ADDR_W-1:2]; the word after the last stage is status.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    input  logic                             lock_i,
    input  logic                             err_i,
    output logic [31:0]                      rdata,
    output div_cfg_t [NUM_STAGES-1:0]        act_cfg,
    output div_cfg_t [NUM_STAGES-1:0]        nxt_cfg,
    output logic                             commit
);
    localparam int SEL_W = ADDR_W - 2;
    localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_STAGES);

    div_cfg_t [NUM_STAGES-1:0] shadow;
    logic [SEL_W-1:0]          sel;
    logic                      stage_hit;
    logic                      unused_bits;

    assign sel         = addr[ADDR_W-1:2];
    assign stage_hit   = wr_en && (sel < STATUS_SEL);
    assign commit      = stage_hit && !wdata[HOLD_BIT];
    assign unused_bits = ^{addr[1:0], wdata[31:CFG_W]};

    // Merge the incoming write into the shadow view used for the next state.
    always_comb begin
        for (int i = 0; i < NUM_STAGES; i++) begin
            nxt_cfg[i] = shadow[i];
            if (stage_hit && sel == SEL_W'(i)) nxt_cfg[i] = div_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    // Shadow registers take every stage write.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= {NUM_STAGES{RESET_CFG}};
        else        shadow <= nxt_cfg;
    end

    // Active registers take all merged shadows at once on an apply.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_cfg <= {NUM_STAGES{RESET_CFG}};
        else if (commit) act_cfg <= nxt_cfg;
    end

    // Read mux: shadow contents with reserved bits zero, or the status word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_STAGES; i++)
            if (sel == SEL_W'(i)) rdata[CFG_W-1:0] = shadow[i];
        if (sel == STATUS_SEL) rdata[1:0] = {err_i, lock_i};
    end

    // R3
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_hit && wdata[HOLD_BIT]) |=> $stable(act_cfg))
        else $error("hold write changed active settings");

    // R4
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_cfg == shadow))
        else $error("apply did not copy all shadows");
endmodule

// File: rtl/clkdiv_stage.sv
// One divider stage: high phase then low phase from latched counts.
// Assumes active settings may change at any edge; it latches them only at period end.
module clkdiv_stage
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t act_cfg,
    output logic     div_clk_o
);
    logic [CNT_W-1:0] cur_hi, cur_lo, cnt, hi_eff, lo_eff;
    logic             cur_pass, ph_high, period_end;
    logic             unused_cfg;

    assign unused_cfg = ^{act_cfg.hold, act_cfg.odd_flag};
    assign hi_eff     = (cur_hi == '0) ? CNT_W'(1) : cur_hi;
    assign lo_eff     = (cur_lo == '0) ? CNT_W'(1) : cur_lo;
    assign period_end = cur_pass || (!ph_high && cnt == lo_eff - CNT_W'(1));

    // Phase counter: reload at period end, otherwise step through high then low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_hi <= '0; cur_lo <= '0; cur_pass <= 1'b1;
            ph_high <= 1'b1; cnt <= '0;
        end else if (period_end) begin
            cur_hi   <= act_cfg.hi_cnt;
            cur_lo   <= act_cfg.lo_cnt;
            cur_pass <= act_cfg.pass;
            ph_high  <= 1'b1;
            cnt      <= '0;
        end else if (ph_high && cnt == hi_eff - CNT_W'(1)) begin
            ph_high <= 1'b0;
            cnt     <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign div_clk_o = cur_pass ? clk : ph_high;

    // R5
    hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_pass && ph_high) |-> (cnt < hi_eff))
        else $error("high phase overran its count");

    // R8
    no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ph_high) && !$past(cur_pass)) |-> ($stable(cur_hi) && $stable(cur_lo)))
        else $error("stage reloaded outside period end");
endmodule

// File: rtl/clkdiv_lock.sv
// Lock and error model: lock falls on apply, rises after RELOCK_CYCLES cycles.
// Assumes nxt_cfg is the full setting set being applied in the commit cycle.
module clkdiv_lock
    import clkdiv_pkg::*;
#(
    parameter int RELOCK_CYCLES = 25000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  div_cfg_t [NUM_STAGES-1:0] nxt_cfg,
    output logic                      lock_o,
    output logic                      err_o
);
    localparam int TMR_W = $clog2(RELOCK_CYCLES + 1);

    logic [TMR_W-1:0] tmr;
    logic             bad_cfg;
    logic             unused_cfg;

    // Flag a non-pass stage with a zero count in the settings being applied.
    always_comb begin
        bad_cfg    = 1'b0;
        unused_cfg = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (!nxt_cfg[i].pass && (nxt_cfg[i].hi_cnt == '0 || nxt_cfg[i].lo_cnt == '0))
                bad_cfg = 1'b1;
            unused_cfg = unused_cfg ^ nxt_cfg[i].hold ^ nxt_cfg[i].odd_flag;
        end
    end

    // Relock timer and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0; lock_o <= 1'b1;
        end else if (commit) begin
            tmr <= TMR_W'(RELOCK_CYCLES); lock_o <= 1'b0;
        end else if (tmr != '0) begin
            tmr <= tmr - TMR_W'(1);
            if (tmr == TMR_W'(1)) lock_o <= 1'b1;
        end
    end

    // Error flag updates only on an apply.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_o <= 1'b0;
        else if (commit) err_o <= bad_cfg;
    end

    // R9
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !lock_o)
        else $error("lock stayed up after apply");

    // R9
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && tmr == TMR_W'(1) && !commit) |=> lock_o)
        else $error("lock did not return at end of relock");

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(err_o))
        else $error("error flag moved without an apply");
endmodule

// File: rtl/clkdiv_bank.sv
// Top of the three-stage divider bank: register port, stages, lock model.
// Assumes a single reference clock; divided clocks are phase registers or the reference itself.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int RELOCK_CYCLES = 25000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic [NUM_STAGES-1:0] div_clk_o,
    output logic                  lock_o,
    output logic                  err_o
);
    div_cfg_t [NUM_STAGES-1:0] act_cfg, nxt_cfg;
    logic                      commit;

    clkdiv_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lock_i(lock_o), .err_i(err_o), .rdata(rdata),
        .act_cfg(act_cfg), .nxt_cfg(nxt_cfg), .commit(commit)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        clkdiv_stage u_stage (
            .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg[g]), .div_clk_o(div_clk_o[g])
        );
    end

    clkdiv_lock #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .commit(commit), .nxt_cfg(nxt_cfg),
        .lock_o(lock_o), .err_o(err_o)
    );
endmodule

// File: tb/test_clkdiv_bank.sv
// Scoreboard bench: tasks push expected period shapes, a monitor measures them.
module test_clkdiv_bank;
    localparam int RL = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  div_clk;
    logic        lock, err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct { int stage; int hi; int lo; string tag; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    clkdiv_bank #(.ADDR_W(4), .RELOCK_CYCLES(RL)) i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .div_clk_o(div_clk), .lock_o(lock), .err_o(err)
    );

    function automatic logic [31:0] enc(int hi, int lo, bit odd, bit pass, bit hold);
        return {17'b0, hold, pass, odd, 6'(hi), 6'(lo)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic push_exp(int s, int hi, int lo, string tag);
        exp_t e; e.stage = s; e.hi = hi; e.lo = lo; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check_follow(int s, string tag);
        @(posedge clk); #1; chk(tag, 32'(div_clk[s]), 1);
        @(negedge clk); #1; chk(tag, 32'(div_clk[s]), 0);
    endtask

    // Monitor: measure one full period of the named stage, then compare.
    initial begin
        forever begin
            exp_t e; int h; int l; logic p;
            wait (exp_q.size() > 0);
            e = exp_q[0];
            @(negedge clk); p = div_clk[e.stage];
            forever begin
                @(negedge clk);
                if (!p && div_clk[e.stage]) break;
                p = div_clk[e.stage];
            end
            h = 1;
            forever begin @(negedge clk); if (div_clk[e.stage]) h++; else break; end
            l = 1;
            forever begin @(negedge clk); if (!div_clk[e.stage]) l++; else break; end
            chk({e.tag, " high"}, 32'(h), 32'(e.hi));
            chk({e.tag, " low"},  32'(l), 32'(e.lo));
            void'(exp_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hc, lc;
        logic p;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, d); chk("R1 stage0 reg", d, 32'h2000);
        bus_read(4'h4, d); chk("R1 stage1 reg", d, 32'h2000);
        bus_read(4'h8, d); chk("R1 stage2 reg", d, 32'h2000);
        bus_read(4'hC, d); chk("R1 status", d, 32'h1);
        chk("R1 lock", 32'(lock), 1);
        chk("R1 err", 32'(err), 0);
        check_follow(0, "R6 reset pass-through");

        // R2 status is read-only; reserved bits read zero; low address bits ignored
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC, d); chk("R2 status write ignored", d, 32'h1);
        bus_write(4'h1, 32'hFFFF_C082);
        bus_read(4'h0, d); chk("R2 reserved zero", d, 32'h4082);

        // R3 staging writes, R7 odd flag readback
        bus_write(4'h4, enc(3, 4, 1, 0, 1));
        bus_read(4'h4, d); chk("R7 odd flag stored", d, 32'h50C4);
        chk("R3 lock unchanged", 32'(lock), 1);
        check_follow(0, "R3 stage0 unchanged");
        check_follow(1, "R3 stage1 unchanged");

        // R4 apply via stage 2, R9 relock timing
        bus_write(4'h8, enc(5, 5, 0, 0, 0));
        #1; chk("R9 lock falls", 32'(lock), 0);
        chk("R10 err clear", 32'(err), 0);
        push_exp(0, 2, 2, "R4 stage0 applied");
        push_exp(1, 3, 4, "R5 odd ratio 7 / R7");
        push_exp(2, 5, 5, "R5 stage2 even");
        repeat (RL - 1) @(negedge clk);
        #1; chk("R9 lock still low", 32'(lock), 0);
        @(negedge clk); #1; chk("R9 lock back", 32'(lock), 1);
        wait (exp_q.size() == 0);

        // R8 apply in the middle of a high phase
        @(negedge clk); p = div_clk[2];
        forever begin
            @(negedge clk);
            if (!p && div_clk[2]) break;
            p = div_clk[2];
        end
        hc = 1;
        wr_en = 1'b1; addr = 4'h8; wdata = enc(2, 3, 1, 0, 0);
        @(negedge clk); wr_en = 1'b0;
        if (div_clk[2]) begin
            hc++;
            forever begin @(negedge clk); if (div_clk[2]) hc++; else break; end
        end
        lc = 1;
        forever begin @(negedge clk); if (!div_clk[2]) lc++; else break; end
        chk("R8 high kept", 32'(hc), 5);
        chk("R8 low kept", 32'(lc), 5);
        push_exp(2, 2, 3, "R8 new values next period");
        wait (exp_q.size() == 0);

        // R10 zero count sets error and runs as one cycle
        bus_write(4'h0, enc(0, 3, 0, 0, 1));
        bus_write(4'h8, enc(2, 3, 1, 0, 0));
        bus_read(4'hC, d); chk("R10 status err", d, 32'h2);
        chk("R10 err port", 32'(err), 1);
        push_exp(0, 1, 3, "R10 zero high as one");
        wait (exp_q.size() == 0);
        bus_write(4'h0, enc(2, 2, 0, 0, 0));
        #1; chk("R10 err cleared", 32'(err), 0);

        // R6 pass-through with zero counts is not an error
        bus_write(4'h4, enc(0, 0, 0, 1, 0));
        #1; chk("R10 pass no err", 32'(err), 0);
        repeat (10) @(negedge clk);
        check_follow(1, "R6 stage1 follows ref");

        // R9 restart of relock by a second apply
        repeat (RL + 2) @(negedge clk);
        bus_write(4'h0, enc(2, 2, 0, 0, 0));
        repeat (10) @(negedge clk);
        bus_write(4'h0, enc(2, 2, 0, 0, 0));
        repeat (RL - 1) @(negedge clk);
        #1; chk("R9 restart low", 32'(lock), 0);
        @(negedge clk); #1; chk("R9 restart rise", 32'(lock), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule